// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block is the transmit half of a single-channel audio codec link. A simple write port carries bus writes to five addresses: sample data, transmit control, interrupt mask, interrupt clear and interface control. Each sample is padded to a left-justified 20-bit value and stored in a circular FIFO of `DEPTH` entries. In compact mode one data write carries two 16-bit (or 12-bit) samples.

Draining to the codec starts only when the FIFO is at least half full and transmit is enabled on a data slot. Entries then leave as stereo pairs over a valid/ready handshake. Once started, a burst goes on while the codec keeps accepting pairs. The block keeps four hysteretic transmit flags, derives three interrupt status bits from them, and drives one masked interrupt line. Serial frame timing, the receive path and the codec itself lie outside it.

Top module: `audio_tx_fifo`

## Requirements
- R1: After synchronous reset the level is 0, `tx_flags` is 4'b0011 (bit0 empty, bit1 half-empty, bit2 full, bit3 underrun), `codec_valid` is low and `irq` is low.
- R2: Write address 1 loads transmit control: bit0 enable, bit1 slot-3 enable, bit2 slot-4 enable, bits[4:3] size code (0=16, 1=18, 2=20, 3=12 bits), bit5 compact. A non-compact write to address 0 stores one entry: `wr_data[19:0]` shifted left by 4, 2, 0 or 8 for size codes 0, 1, 2 and 3, keeping the low 20 bits.
- R3: In compact mode a data write stores two entries, bits[15:0] first and bits[31:16] second, each shifted left by 8 for size code 3 and by 4 otherwise. The compact bit is ignored when the size code is 1 or 2.
- R4: A non-compact write is accepted only when level < DEPTH. A compact write is accepted only when level + 2 < DEPTH. A write that is refused is dropped, and the level never exceeds DEPTH.
- R5: `codec_valid` is high only with enable set, slot 3 or slot 4 set, level >= 2, and either level >= DEPTH/2 or a burst in progress. `codec_pair[39:20]` holds the older (left) entry and `codec_pair[19:0]` the next (right) one.
- R6: Each cycle with valid and ready removes one pair. While ready stays high, the burst continues below half full until fewer than 2 entries remain. A cycle with valid high and ready low ends the burst after that cycle.
- R7: After an accepted push, empty and underrun clear. Half-empty clears if the level after the push is >= DEPTH/2, and full sets if it reaches DEPTH.
- R8: After a pair drains, full clears and half-empty sets if the level is <= DEPTH/2. Empty and underrun both set if the level reaches 0. These rules apply after the push rules of the same cycle.
- R9: `int_status` bit0 = underrun, bit1 = half-empty, bit2 = empty and not draining. Address 2 bits[2:0] load the mask, and `irq` is the OR of `int_status` AND mask.
- R10: Writing address 3 with bit0 set clears the underrun flag.
- R11: Writing address 4 with bit0 clear empties the FIFO, clears control, mask and burst state, and returns the flags to 4'b0011. Writing address 4 with bit0 set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 data, 1 control, 2 mask, 3 clear, 4 interface) |
| wr_data | input | 32 | Write data |
| codec_ready | input | 1 | Codec accepts a pair this cycle |
| codec_valid | output | 1 | A stereo pair is offered |
| codec_pair | output | 40 | {left, right} 20-bit samples |
| fifo_level | output | $clog2(DEPTH)+1 | Entries held |
| tx_flags | output | 4 | {underrun, full, half-empty, empty} |
| int_status | output | 3 | {complete, transmit, underrun} interrupt status |
| irq | output | 1 | Masked interrupt |

## Verification
A data push and a pair drain can fall in the same cycle. The level then moves by the net amount, and the push flag rules and the drain flag rules both act on the flags, drain last. The bench provokes this by writing samples while `codec_ready` is held high during a burst, both in directed sequences and heavily in the random phase. A cycle model that applies the push rules on the mid level and then the drain rules on the final level judges every cycle's level, flags, pair and interrupt outputs.

// File: rtl/atx_pkg.sv
package atx_pkg;

    localparam int SAMPLE_W = 20;
    localparam int PAIR_W   = 2 * SAMPLE_W;

    typedef enum logic [2:0] {
        ADDR_DATA   = 3'd0,
        ADDR_TXCTRL = 3'd1,
        ADDR_IMASK  = 3'd2,
        ADDR_ICLR   = 3'd3,
        ADDR_MAIN   = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        SZ16 = 2'd0,
        SZ18 = 2'd1,
        SZ20 = 2'd2,
        SZ12 = 2'd3
    } size_e;

    typedef struct packed {
        logic  compact;
        size_e size;
        logic  slot4;
        logic  slot3;
        logic  tx_en;
    } txctrl_t;

    typedef struct packed {
        logic underrun;
        logic full;
        logic half_empty;
        logic empty;
    } txflags_t;

    localparam txflags_t FLAGS_RST = '{underrun: 1'b0, full: 1'b0,
                                       half_empty: 1'b1, empty: 1'b1};

    // Compact packing only exists for the two narrow sizes.
    function automatic txctrl_t decode_ctrl(input logic [31:0] w);
        txctrl_t c;
        c.tx_en   = w[0];
        c.slot3   = w[1];
        c.slot4   = w[2];
        c.size    = size_e'(w[4:3]);
        c.compact = w[5] && (c.size == SZ16 || c.size == SZ12);
        return c;
    endfunction

    // Left-justify a sample of the selected width into 20 bits.
    function automatic logic [SAMPLE_W-1:0] pad_sample(input logic [SAMPLE_W-1:0] raw,
                                                       input size_e sz);
        logic [SAMPLE_W-1:0] r;
        case (sz)
            SZ12:    r = raw << 8;
            SZ16:    r = raw << 4;
            SZ18:    r = raw << 2;
            default: r = raw;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/atx_ctrl_regs.sv
module atx_ctrl_regs
    import atx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        reg_wr,
    input  reg_addr_e   addr,
    input  logic [31:0] wdata,
    output txctrl_t     ctrl_q,
    output logic [2:0]  imask_q,
    output logic        clr_underrun
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ctrl_q  <= '0;
            imask_q <= '0;
        end else if (reg_wr) begin
            if (addr == ADDR_TXCTRL) ctrl_q  <= decode_ctrl(wdata);
            if (addr == ADDR_IMASK)  imask_q <= wdata[2:0];
        end
    end

    assign clr_underrun = reg_wr && (addr == ADDR_ICLR) && wdata[0];

endmodule

// File: rtl/atx_packer.sv
module atx_packer
    import atx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic                data_wr,
    input  logic [31:0]         wdata,
    input  txctrl_t             ctrl,
    input  logic [LW-1:0]       level,
    output logic [1:0]          push_n,
    output logic [SAMPLE_W-1:0] s0,
    output logic [SAMPLE_W-1:0] s1
);

    always_comb begin
        push_n = 2'd0;
        if (ctrl.compact) begin
            s0 = pad_sample({4'b0, wdata[15:0]}, ctrl.size);
            s1 = pad_sample({4'b0, wdata[31:16]}, ctrl.size);
            if (data_wr && (int'(level) + 2 < DEPTH)) push_n = 2'd2;
        end else begin
            s0 = pad_sample(wdata[SAMPLE_W-1:0], ctrl.size);
            s1 = '0;
            if (data_wr && (int'(level) < DEPTH)) push_n = 2'd1;
        end
    end

endmodule

// File: rtl/atx_fifo.sv
module atx_fifo
    import atx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic [1:0]          push_n,
    input  logic [SAMPLE_W-1:0] s0,
    input  logic [SAMPLE_W-1:0] s1,
    input  logic                pop,
    output logic [LW-1:0]       level,
    output logic [PAIR_W-1:0]   head_pair
);

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [AW-1:0]       wptr, rptr;
    logic [AW-1:0]       wptr_nx, rptr_nx;

    assign wptr_nx = wptr + AW'(1);
    assign rptr_nx = rptr + AW'(1);

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wptr]    <= s0;
        if (push_n == 2'd2) mem[wptr_nx] <= s1;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            wptr  <= wptr + AW'(push_n);
            if (pop) rptr <= rptr + AW'(2);
            level <= level + LW'(push_n) - (pop ? LW'(2) : LW'(0));
        end
    end

    assign head_pair = {mem[rptr], mem[rptr_nx]};

endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
    import atx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              codec_ready,
    output logic              codec_valid,
    output logic [PAIR_W-1:0] codec_pair,
    output logic [LW-1:0]     fifo_level,
    output logic [3:0]        tx_flags,
    output logic [2:0]        int_status,
    output logic              irq
);

    localparam int HALF = DEPTH / 2;

    reg_addr_e           addr;
    logic                flush, reg_wr, data_wr;
    txctrl_t             ctrl_q;
    logic [2:0]          imask_q;
    logic                clr_underrun;
    logic [1:0]          push_n;
    logic [SAMPLE_W-1:0] s0, s1;
    logic [LW-1:0]       level;
    logic                drain_ok, pop;
    logic                burst_q, burst_d;
    logic [LW:0]         mid_lvl, fin_lvl;
    txflags_t            flags_q, flags_d;

    assign addr    = reg_addr_e'(wr_addr);
    assign flush   = wr_en && (addr == ADDR_MAIN) && !wr_data[0];
    assign reg_wr  = wr_en && !flush;
    assign data_wr = wr_en && (addr == ADDR_DATA);

    atx_ctrl_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .reg_wr       (reg_wr),
        .addr         (addr),
        .wdata        (wr_data),
        .ctrl_q       (ctrl_q),
        .imask_q      (imask_q),
        .clr_underrun (clr_underrun)
    );

    atx_packer #(.DEPTH(DEPTH)) u_pack (
        .data_wr (data_wr),
        .wdata   (wr_data),
        .ctrl    (ctrl_q),
        .level   (level),
        .push_n  (push_n),
        .s0      (s0),
        .s1      (s1)
    );

    atx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push_n    (push_n),
        .s0        (s0),
        .s1        (s1),
        .pop       (pop),
        .level     (level),
        .head_pair (codec_pair)
    );

    // Draining opens at half full and then runs on as a burst.
    assign drain_ok = !flush && ctrl_q.tx_en && (ctrl_q.slot3 || ctrl_q.slot4)
                      && (int'(level) >= 2)
                      && ((int'(level) >= HALF) || burst_q);
    assign pop      = drain_ok && codec_ready;

    assign mid_lvl  = {1'b0, level} + (LW+1)'(push_n);
    assign fin_lvl  = mid_lvl - (pop ? (LW+1)'(2) : (LW+1)'(0));
    assign burst_d  = pop && (int'(fin_lvl) >= 2);

    // Flag update order: clear request, then push rules, then drain rules.
    always_comb begin
        flags_d = flags_q;
        if (clr_underrun) flags_d.underrun = 1'b0;
        if (push_n != 2'd0) begin
            flags_d.empty    = 1'b0;
            flags_d.underrun = 1'b0;
            if (int'(mid_lvl) >= HALF)  flags_d.half_empty = 1'b0;
            if (int'(mid_lvl) >= DEPTH) flags_d.full       = 1'b1;
        end
        if (pop) begin
            flags_d.full = 1'b0;
            if (int'(fin_lvl) <= HALF) flags_d.half_empty = 1'b1;
            if (fin_lvl == '0) begin
                flags_d.empty    = 1'b1;
                flags_d.underrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            flags_q <= FLAGS_RST;
            burst_q <= 1'b0;
        end else begin
            flags_q <= flags_d;
            burst_q <= burst_d;
        end
    end

    assign codec_valid = drain_ok;
    assign fifo_level  = level;
    assign tx_flags    = flags_q;
    assign int_status  = {flags_q.empty && !drain_ok, flags_q.half_empty, flags_q.underrun};
    assign irq         = |(int_status & imask_q);

endmodule

// File: rtl/atx_checker.sv
module atx_checker
    import atx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          codec_valid,
    input logic          codec_ready,
    input logic [LW-1:0] fifo_level,
    input logic [3:0]    tx_flags,
    input txctrl_t       ctrl
);

    a_r4_level_bound: assert property (@(posedge clk) disable iff (rst)
        int'(fifo_level) <= DEPTH);

    a_r7_full_level: assert property (@(posedge clk) disable iff (rst)
        tx_flags[2] == (int'(fifo_level) == DEPTH));

    a_r8_empty_level: assert property (@(posedge clk) disable iff (rst)
        tx_flags[0] == (fifo_level == '0));

    a_r8_underrun_empty: assert property (@(posedge clk) disable iff (rst)
        tx_flags[3] |-> tx_flags[0]);

    a_r5_valid_gate: assert property (@(posedge clk) disable iff (rst)
        codec_valid |-> (ctrl.tx_en && (ctrl.slot3 || ctrl.slot4) && int'(fifo_level) >= 2));

    a_r6_pair_step: assert property (@(posedge clk) disable iff (rst)
        (codec_valid && codec_ready && !wr_en) |=> (int'(fifo_level) == int'($past(fifo_level)) - 2));

endmodule

bind audio_tx_fifo atx_checker #(.DEPTH(DEPTH)) u_atx_checker (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .codec_valid (codec_valid),
    .codec_ready (codec_ready),
    .fifo_level  (fifo_level),
    .tx_flags    (tx_flags),
    .ctrl        (ctrl_q)
);

// File: tb/test_audio_tx_fifo.sv
module test_audio_tx_fifo;

    localparam int D  = 8;
    localparam int LW = $clog2(D) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          codec_ready = 1'b0;
    logic          codec_valid;
    logic [39:0]   codec_pair;
    logic [LW-1:0] fifo_level;
    logic [3:0]    tx_flags;
    logic [2:0]    int_status;
    logic          irq;

    audio_tx_fifo #(.DEPTH(D)) i_audio_tx_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .codec_ready(codec_ready), .codec_valid(codec_valid), .codec_pair(codec_pair),
        .fifo_level(fifo_level), .tx_flags(tx_flags), .int_status(int_status), .irq(irq)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Bench model state
    logic [19:0] q[$];
    bit mf_e = 1, mf_h = 1, mf_f = 0, mf_u = 0;
    bit m_en = 0, m_s3 = 0, m_s4 = 0, m_cmp = 0, m_burst = 0;
    bit [1:0] m_sz = 0;
    bit [2:0] m_mask = 0;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [19:0] exp_pad(input logic [31:0] v, input bit [1:0] sz);
        logic [31:0] t;
        case (sz)
            2'd0:    t = v * 16;
            2'd1:    t = v * 4;
            2'd2:    t = v;
            default: t = v * 256;
        endcase
        return t[19:0];
    endfunction

    task automatic cycle(input bit we, input bit [2:0] a, input bit [31:0] d, input bit rdy);
        bit flush, active, pop, clr;
        int lvl, mid, fin, npush;
        bit [2:0] e_int;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; codec_ready = rdy;
        #1;
        flush  = we && a == 3'd4 && !d[0];
        lvl    = q.size();
        active = !flush && m_en && (m_s3 || m_s4) && lvl >= 2 && (lvl >= D/2 || m_burst);
        e_int  = {mf_e && !active, mf_h, mf_u};
        chk(codec_valid, active, "R5 valid");
        if (active) chk(codec_pair, {q[0], q[1]}, "R2 pair data");
        chk(fifo_level, lvl, "R4 level");
        chk(tx_flags, {mf_u, mf_f, mf_h, mf_e}, "R7 flags");
        chk(int_status, e_int, "R9 int_status");
        chk(irq, |(e_int & m_mask), "R9 irq");
        // next state
        pop = active && rdy;
        if (flush) begin
            q.delete();
            {mf_u, mf_f, mf_h, mf_e} = 4'b0011;
            {m_en, m_s3, m_s4, m_cmp, m_burst} = '0; m_sz = 0; m_mask = 0;
        end else begin
            clr = we && a == 3'd3 && d[0];
            npush = 0;
            if (we && a == 3'd0) begin
                if (m_cmp) begin
                    if (lvl + 2 < D) begin
                        q.push_back(exp_pad({16'h0, d[15:0]}, m_sz));
                        q.push_back(exp_pad({16'h0, d[31:16]}, m_sz));
                        npush = 2;
                    end
                end else if (lvl < D) begin
                    q.push_back(exp_pad(d, m_sz));
                    npush = 1;
                end
            end
            mid = lvl + npush;
            if (pop) begin void'(q.pop_front()); void'(q.pop_front()); end
            fin = q.size();
            if (clr) mf_u = 0;
            if (npush > 0) begin
                mf_e = 0; mf_u = 0;
                if (mid >= D/2) mf_h = 0;
                if (mid >= D) mf_f = 1;
            end
            if (pop) begin
                mf_f = 0;
                if (fin <= D/2) mf_h = 1;
                if (fin == 0) begin mf_e = 1; mf_u = 1; end
            end
            m_burst = pop && fin >= 2;
            if (we && a == 3'd1) begin
                m_en = d[0]; m_s3 = d[1]; m_s4 = d[2]; m_sz = d[4:3];
                m_cmp = d[5] && (d[4:3] == 2'd0 || d[4:3] == 2'd3);
            end
            if (we && a == 3'd2) m_mask = d[2:0];
        end
    endtask

    task automatic wr(input bit [2:0] a, input bit [31:0] d, input bit rdy = 0);
        cycle(1, a, d, rdy);
    endtask

    task automatic idle(input bit rdy = 0);
        cycle(0, 3'd0, 32'd0, rdy);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog (all R) actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd7741));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        #1;
        chk(fifo_level, 0, "R1 level");
        chk(tx_flags, 4'b0011, "R1 flags");
        chk(codec_valid, 0, "R1 valid");
        chk(irq, 0, "R1 irq");

        // R2 padding per size code
        wr(1, 32'h18);              // size code 3, disabled
        wr(0, 32'h00ABC);
        wr(0, 32'h00123);
        wr(1, 32'h00);              // size code 0
        wr(0, 32'h01234);
        wr(0, 32'hFFFFF);
        idle();
        chk(fifo_level, 4, "R4 four accepted");
        chk(tx_flags, 4'b0000, "R7 half-empty cleared at half");
        wr(1, 32'h03);              // enable + slot3
        idle();
        chk(codec_valid, 1, "R5 drain at half");
        chk(codec_pair, {20'hABC00, 20'h12300}, "R2 12-bit pad pair");
        chk(int_status, 3'b000, "R9 status while filled");
        idle(1);
        idle();
        chk(fifo_level, 2, "R6 one pair moved");
        chk(codec_valid, 1, "R6 burst continues below half");
        chk(codec_pair, {20'h12340, 20'hFFFF0}, "R2 16-bit pad pair");
        idle();
        chk(codec_valid, 0, "R6 refusal ends burst");
        chk(tx_flags, 4'b0010, "R8 half-empty after drain");

        // R8 drain to empty, R9/R10 interrupts
        wr(1, 32'h0B, 1);           // size code 1
        wr(0, 32'h3FFFF, 1);
        wr(0, 32'hCAFE5, 1);
        idle(1); idle(1); idle(1);
        idle();
        chk(fifo_level, 0, "R8 drained");
        chk(tx_flags, 4'b1011, "R8 empty+underrun");
        chk(int_status, 3'b111, "R9 all status");
        wr(2, 32'h1);
        idle();
        chk(irq, 1, "R9 underrun irq");
        wr(3, 32'h1);
        idle();
        chk(tx_flags, 4'b0011, "R10 underrun cleared");
        chk(irq, 0, "R10 irq dropped");

        // R3 compact, R4 limits
        wr(1, 32'h20);
        wr(0, 32'h56781234);
        wr(0, 32'h00200010);
        idle();
        chk(fifo_level, 4, "R3 two per write");
        wr(1, 32'h28);              // compact with 18-bit: ignored
        wr(0, 32'h1);
        idle();
        chk(fifo_level, 5, "R3 compact forced off");
        wr(1, 32'h20);
        wr(0, 32'h11112222);
        wr(0, 32'h33334444);
        idle();
        chk(fifo_level, 7, "R4 compact refused at level+2>=depth");
        wr(1, 32'h00);
        wr(0, 32'h77);
        wr(0, 32'h88);
        idle();
        chk(fifo_level, 8, "R4 full refuses write");
        chk(tx_flags, 4'b0100, "R7 full set");
        wr(1, 32'h05);              // enable + slot4
        idle();
        chk(codec_pair, {20'h12340, 20'h56780}, "R3 compact order");
        repeat (5) idle(1);
        idle();
        chk(fifo_level, 0, "R6 burst drains all");

        // R11 flush
        wr(0, 32'h5); wr(0, 32'h6);
        wr(4, 32'h1);
        idle();
        chk(fifo_level, 2, "R11 bit0 set no effect");
        wr(4, 32'h0);
        idle();
        chk(fifo_level, 0, "R11 flush level");
        chk(tx_flags, 4'b0011, "R11 flush flags");
        repeat (4) wr(0, 32'h9);
        idle();
        chk(codec_valid, 0, "R11 control cleared");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            bit rdy;
            bit [31:0] d;
            r   = $urandom_range(0, 99);
            rdy = ($urandom_range(0, 9) < 6);
            d   = $urandom();
            if (r < 50)      wr(0, d, rdy);
            else if (r < 56) wr(1, {26'h0, d[5:1], ($urandom_range(0, 3) != 0)}, rdy);
            else if (r < 59) wr(2, d, rdy);
            else if (r < 62) wr(3, d, rdy);
            else if (r < 64) wr(4, {d[31:1], ($urandom_range(0, 3) != 0)}, rdy);
            else             idle(rdy);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule